// File: doc/BRIEF.md
# Set/Clear GPIO Port with Armed Input Path

A 32-pin general-purpose I/O port on a simple register bus (address, write enable, write data, read enable, read data). Pins have no direction register. Software changes a pin's output value only through a write-one-to-set register and a write-one-to-clear register. Either of those writes also makes each written pin drive its pad. A separate release register is the only way to return pins to input (tristate). Each pin maps to the register bit of the same index.

The pin inputs pass through a two-flop synchronizer. Reads of the live pin state return zero until software has written the arming register once, with any data value. A small two-state machine tracks this. It resets to `DISARMED`. The transition `ARM`, taken on any write to the arming offset, moves it to `ARMED`. `ARMED` loops on itself until reset. Read data is registered: it appears the cycle after a read strobe and is zero in any cycle that follows no read.

Register offsets: release/drive status at 0x100, set/latch at 0x108, clear at 0x10C, pin state/arm at 0x110.

Top module: `scg_gpio_port`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all zero), the output latch (`pad_out`) is zero and the input path is disarmed.
- R2: A write to 0x108 sets the latch bits that are one in the write data. All other latch bits keep their value.
- R3: A write to 0x10C clears the latch bits that are one in the write data. All other latch bits keep their value.
- R4: A write to 0x108 or 0x10C makes each pin whose data bit is one drive its pad (`pad_oe` bit set). Pins whose data bit is zero keep their drive state. A clear write never releases a pin.
- R5: A write to 0x100 releases each pin whose data bit is one (`pad_oe` bit cleared). Other pins and the whole latch are unchanged.
- R6: When `bus_re` is high at a clock edge, `bus_rdata` after that edge holds the selected register. 0x100 returns the drive status (1 = driving), and 0x108 returns the latch. After an edge with `bus_re` low, `bus_rdata` is zero.
- R7: While the input path is disarmed, a read of 0x110 returns zero whatever the pad levels.
- R8: Any write to 0x110, including one with data zero, arms the input path. It stays armed until reset, and later writes elsewhere do not disarm it.
- R9: When armed, a read of 0x110 returns `pad_in` delayed by two clock edges. A level applied before edge k is returned by a read sampled at edge k+2, and a read sampled at edge k still returns the old level.
- R10: A read of 0x10C or of any unmapped offset returns zero. A write to an unmapped offset changes neither `pad_out` nor `pad_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data / pin mask |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_out | output | 32 | Output value for each pad |
| pad_oe | output | 32 | Output enable for each pad (1 = drive) |
| pad_in | input | 32 | Raw pad levels |

## Verification
Set and clear writes are tried with masks on the low byte, on a single middle pin and on the top pin. A clear on a pin that was never driven distinguishes "clear also drives" from "clear only zeroes". Release masks that cover only some driven pins, followed by one that covers all pins, show that release affects drive status but leaves the latch alone. Pin state is read with all-ones pads before arming, right after an arming write of zero data, and across a pad change sampled one and two edges late. These reads separate the arm gate from the synchronizer delay, and a mid-run reset confirms that arming is lost.

// File: rtl/scg_pkg.sv
package scg_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_REL,
        SEL_SET,
        SEL_CLR,
        SEL_PIN
    } scg_sel_e;

    typedef enum logic {
        ST_DISARMED,
        ST_ARMED
    } scg_arm_e;

endpackage

// File: rtl/scg_addr_dec.sv
module scg_addr_dec
    import scg_pkg::*;
#(
    parameter int AW      = 12,
    parameter int OFF_REL = 'h100,
    parameter int OFF_SET = 'h108,
    parameter int OFF_CLR = 'h10C,
    parameter int OFF_PIN = 'h110
) (
    input  logic [AW-1:0] addr,
    output scg_sel_e      sel
);
    localparam logic [AW-1:0] A_REL = AW'(OFF_REL);
    localparam logic [AW-1:0] A_SET = AW'(OFF_SET);
    localparam logic [AW-1:0] A_CLR = AW'(OFF_CLR);
    localparam logic [AW-1:0] A_PIN = AW'(OFF_PIN);

    always_comb begin
        if (addr == A_REL)      sel = SEL_REL;
        else if (addr == A_SET) sel = SEL_SET;
        else if (addr == A_CLR) sel = SEL_CLR;
        else if (addr == A_PIN) sel = SEL_PIN;
        else                    sel = SEL_NONE;
    end
endmodule

// File: rtl/scg_pin_bank.sv
module scg_pin_bank #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_set,
    input  logic            wr_clr,
    input  logic            wr_rel,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] out_q,
    output logic [PINS-1:0] oe_q
);
    logic [PINS-1:0] out_d;
    logic [PINS-1:0] oe_d;

    always_comb begin
        out_d = out_q;
        oe_d  = oe_q;
        if (wr_set) begin
            out_d = out_q | wdata;
            oe_d  = oe_q | wdata;
        end else if (wr_clr) begin
            out_d = out_q & ~wdata;
            oe_d  = oe_q | wdata;
        end else if (wr_rel) begin
            oe_d  = oe_q & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
            oe_q  <= '0;
        end else begin
            out_q <= out_d;
            oe_q  <= oe_d;
        end
    end

    AST_SET_RAISES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((out_q & $past(wdata)) == $past(wdata))); // R2
    AST_CLR_DROPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((out_q & $past(wdata)) == '0)); // R3
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set || wr_clr) |=> ((oe_q & $past(wdata)) == $past(wdata))); // R4
    AST_REL_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rel |=> ($stable(out_q) && ((oe_q & $past(wdata)) == '0))); // R5
endmodule

// File: rtl/scg_in_sync.sv
module scg_in_sync #(
    parameter int PINS   = 32,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] raw,
    output logic [PINS-1:0] synced
);
    logic [PINS-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/scg_arm_fsm.sv
module scg_arm_fsm
    import scg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_wr,
    output logic armed
);
    scg_arm_e state_q;
    scg_arm_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISARMED: if (arm_wr) state_d = ST_ARMED;
            ST_ARMED:    state_d = ST_ARMED;
            default:     state_d = ST_DISARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_DISARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_ARMED: armed = 1'b1;
            default:  armed = 1'b0;
        endcase
    end

    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed); // R8
    AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> armed); // R8
endmodule

// File: rtl/scg_gpio_port.sv
module scg_gpio_port
    import scg_pkg::*;
#(
    parameter int PINS    = 32,
    parameter int AW      = 12,
    parameter int STAGES  = 2,
    parameter int OFF_REL = 'h100,
    parameter int OFF_SET = 'h108,
    parameter int OFF_CLR = 'h10C,
    parameter int OFF_PIN = 'h110
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_we,
    input  logic [PINS-1:0] bus_wdata,
    input  logic            bus_re,
    output logic [PINS-1:0] bus_rdata,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    input  logic [PINS-1:0] pad_in
);
    scg_sel_e        sel;
    logic            armed;
    logic [PINS-1:0] out_q;
    logic [PINS-1:0] oe_q;
    logic [PINS-1:0] pin_sync;
    logic [PINS-1:0] rd_mux;
    logic [PINS-1:0] rdata_q;

    scg_addr_dec #(
        .AW(AW), .OFF_REL(OFF_REL), .OFF_SET(OFF_SET),
        .OFF_CLR(OFF_CLR), .OFF_PIN(OFF_PIN)
    ) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    scg_pin_bank #(.PINS(PINS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_set (bus_we && sel == SEL_SET),
        .wr_clr (bus_we && sel == SEL_CLR),
        .wr_rel (bus_we && sel == SEL_REL),
        .wdata  (bus_wdata),
        .out_q  (out_q),
        .oe_q   (oe_q)
    );

    scg_in_sync #(.PINS(PINS), .STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pad_in),
        .synced (pin_sync)
    );

    scg_arm_fsm u_arm (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_wr (bus_we && sel == SEL_PIN),
        .armed  (armed)
    );

    always_comb begin
        unique case (sel)
            SEL_REL: rd_mux = oe_q;
            SEL_SET: rd_mux = out_q;
            SEL_PIN: rd_mux = armed ? pin_sync : '0;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_re) rdata_q <= rd_mux;
        else             rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;
    assign pad_out   = out_q;
    assign pad_oe    = oe_q;

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> (bus_rdata == '0)); // R6
    AST_DISARMED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && sel == SEL_PIN && !armed) |=> (bus_rdata == '0)); // R7
    AST_UNMAPPED_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && sel == SEL_NONE) |=> ($stable(pad_out) && $stable(pad_oe))); // R10
    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && (sel == SEL_NONE || sel == SEL_CLR)) |=> (bus_rdata == '0)); // R10
endmodule

// File: tb/scg_gpio_port_bench.sv
module scg_gpio_port_bench;
    localparam int PINS = 32;
    localparam int AW   = 12;
    localparam logic [1:0] K_W = 2'd0;  // write
    localparam logic [1:0] K_R = 2'd1;  // read and compare
    localparam logic [1:0] K_P = 2'd2;  // compare pad_out
    localparam logic [1:0] K_E = 2'd3;  // compare pad_oe
    localparam int NV = 24;

    // {req[3:0], kind[1:0], addr[11:0], data[31:0], expect[31:0]}
    localparam logic [81:0] VEC [NV] = '{
        {4'd2,  K_W, 12'h108, 32'h0000_00FF, 32'h0},
        {4'd2,  K_P, 12'h000, 32'h0,         32'h0000_00FF}, // R2
        {4'd4,  K_E, 12'h000, 32'h0,         32'h0000_00FF}, // R4
        {4'd3,  K_W, 12'h10C, 32'h0000_000F, 32'h0},
        {4'd3,  K_P, 12'h000, 32'h0,         32'h0000_00F0}, // R3
        {4'd4,  K_E, 12'h000, 32'h0,         32'h0000_00FF}, // R4
        {4'd4,  K_W, 12'h10C, 32'h0001_0000, 32'h0},
        {4'd4,  K_E, 12'h000, 32'h0,         32'h0001_00FF}, // R4
        {4'd3,  K_P, 12'h000, 32'h0,         32'h0000_00F0}, // R3
        {4'd5,  K_W, 12'h100, 32'h0000_0003, 32'h0},
        {4'd5,  K_E, 12'h000, 32'h0,         32'h0001_00FC}, // R5
        {4'd5,  K_P, 12'h000, 32'h0,         32'h0000_00F0}, // R5
        {4'd6,  K_R, 12'h100, 32'h0,         32'h0001_00FC}, // R6
        {4'd6,  K_R, 12'h108, 32'h0,         32'h0000_00F0}, // R6
        {4'd2,  K_W, 12'h108, 32'h8000_0000, 32'h0},
        {4'd2,  K_R, 12'h108, 32'h0,         32'h8000_00F0}, // R2
        {4'd10, K_W, 12'h200, 32'hFFFF_FFFF, 32'h0},
        {4'd10, K_P, 12'h000, 32'h0,         32'h8000_00F0}, // R10
        {4'd10, K_E, 12'h000, 32'h0,         32'h8001_00FC}, // R10
        {4'd10, K_R, 12'h200, 32'h0,         32'h0},         // R10
        {4'd10, K_R, 12'h10C, 32'h0,         32'h0},         // R10
        {4'd5,  K_W, 12'h100, 32'hFFFF_FFFF, 32'h0},
        {4'd5,  K_E, 12'h000, 32'h0,         32'h0},         // R5
        {4'd5,  K_P, 12'h000, 32'h0,         32'h8000_00F0}  // R5
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [PINS-1:0] bus_wdata = '0;
    logic            bus_re = 1'b0;
    logic [PINS-1:0] bus_rdata;
    logic [PINS-1:0] pad_out;
    logic [PINS-1:0] pad_oe;
    logic [PINS-1:0] pad_in = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    scg_gpio_port u_scg_gpio_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
    );

    task automatic check(input int req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        pad_in = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(1, pad_oe, 32'h0, "pad_oe after reset");
        check(1, pad_out, 32'h0, "pad_out after reset");
        bus_read(12'h108, rd);
        check(1, rd, 32'h0, "latch read after reset");
        repeat (3) @(negedge clk);
        bus_read(12'h110, rd);
        check(7, rd, 32'h0, "pin read before arming, pads all ones");
        check(6, bus_rdata, 32'h0, "rdata after idle edge pending");
        @(negedge clk);
        check(6, bus_rdata, 32'h0, "rdata after edge with re low");

        for (int i = 0; i < NV; i++) begin
            automatic int          req  = int'(VEC[i][81:78]);
            automatic logic [1:0]  kind = VEC[i][77:76];
            automatic logic [11:0] a    = VEC[i][75:64];
            automatic logic [31:0] d    = VEC[i][63:32];
            automatic logic [31:0] e    = VEC[i][31:0];
            unique case (kind)
                K_W: bus_write(a, d);
                K_R: begin bus_read(a, rd); check(req, rd, e, "table read"); end
                K_P: check(req, pad_out, e, "table pad_out");
                K_E: check(req, pad_oe, e, "table pad_oe");
            endcase
        end

        // R7 / R8: arming with data zero
        pad_in = 32'hA5A5_0F0F;
        repeat (3) @(negedge clk);
        bus_read(12'h110, rd);
        check(7, rd, 32'h0, "pin read still disarmed");
        bus_write(12'h110, 32'h0);
        bus_read(12'h110, rd);
        check(8, rd, 32'hA5A5_0F0F, "pin read after zero-data arm");

        // R9: two-edge synchronizer delay
        pad_in = 32'h1234_5678;
        bus_read(12'h110, rd);
        check(9, rd, 32'hA5A5_0F0F, "pin read one edge after change");
        @(posedge clk); @(negedge clk);
        bus_read(12'h110, rd);
        check(9, rd, 32'h1234_5678, "pin read two edges after change");

        // R8: other writes do not disarm
        bus_write(12'h100, 32'hFFFF_FFFF);
        bus_write(12'h10C, 32'h0000_0001);
        bus_read(12'h110, rd);
        check(8, rd, 32'h1234_5678, "still armed after other writes");

        // R1 / R7: reset drops arming and drive
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(1, pad_oe, 32'h0, "pad_oe after second reset");
        check(1, pad_out, 32'h0, "pad_out after second reset");
        repeat (3) @(negedge clk);
        bus_read(12'h110, rd);
        check(1, rd, 32'h0, "pin read disarmed after second reset");

        finish_run();
    end
endmodule